// File: doc/BRIEF.md
# Pipelined Row Accumulate-Threshold Slice

This block is one slice of a wide binary associative-memory recall engine. Each clock cycle it may accept one weight row, a word with one bit per column, flagged by a valid input. Every set bit adds one to the counter of its column. The addition sits at the end of a five-register pipeline so the slice can run at a high clock rate. The final row of a pattern carries an end marker. That marker travels down the pipeline with the row. When it reaches the counter stage, the slice compares every column total, including the final row, against a threshold and emits one result word with a one-cycle valid pulse.

Two thresholding modes exist. In fixed mode a column fires when its total reaches a given level. In maximum mode a column fires when its total equals the largest total in the slice, provided that total is nonzero. The mode and the level are taken from the same cycle as the marked final row. The counters return to zero as the result is produced, so the first row of the next pattern can follow the final row with no gap. Several slices can share the same valid, marker and threshold inputs and run in lockstep to widen the datapath. Memory addressing and host control lie outside this block.

Top module: `row_sum_thresh`

## Requirements
- R1: After reset `res_valid` is 0, `res_bits` is 0 and all column counters are 0, so the first pattern starts from zero totals.
- R2: A final row accepted at clock edge k (`in_valid` and `in_last` both high) raises `res_valid` after edge k+4, for exactly one cycle. The data path holds five registers.
- R3: With `thr_mode` = 0 (fixed), bit i of `res_bits` is 1 exactly when the column-i total over the pattern's rows, final row included, is at least `thr_level`.
- R4: With `thr_mode` = 1 (maximum), bit i is 1 exactly when the column-i total equals the largest column total of the pattern and that largest total is above 0.
- R5: `thr_mode` and `thr_level` are used only from the cycle of the final row; their values on other rows have no effect.
- R6: A cycle with `in_valid` low changes no total and ends no pattern, whatever `in_row` and `in_last` hold.
- R7: A row accepted on the cycle right after a final row counts toward a fresh pattern whose totals start at 0.
- R8: Each column total saturates at 2^CNT_W-1 (255 with defaults) and does not wrap.
- R9: `res_bits` holds the most recent result until the next `res_valid` pulse.
- R10: Exactly one `res_valid` pulse is produced for every accepted final row, and no pulse is produced otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row on `in_row` is accepted this cycle |
| in_last | input | 1 | Accepted row is the final row of its pattern |
| in_row | input | COLS | Weight row, one bit per column |
| thr_mode | input | 1 | 0 = fixed level, 1 = maximum selection |
| thr_level | input | CNT_W | Fixed threshold level |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_bits | output | COLS | Thresholded result word |

## Verification
The assertions assume that the control inputs carry known values once reset is released. They also assume that `in_last` has meaning only together with `in_valid`, so the five-cycle correspondence between final rows and pulses can be checked in both directions. The stimulus changes every input on the falling clock edge. It deliberately places junk rows and raised `in_last` on cycles where `in_valid` is low. It also varies the mode and level on non-final rows, so that the sampling rules are exercised without breaking those assumptions.

// File: rtl/row_sum_thresh.sv
module row_sum_thresh #(
  parameter int COLS  = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [COLS-1:0]  in_row,
  input  logic             thr_mode,
  input  logic [CNT_W-1:0] thr_level,
  output logic             res_valid,
  output logic [COLS-1:0]  res_bits
);
  localparam int DLY = 4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [COLS-1:0]  d_row [DLY];
  logic             d_v   [DLY];
  logic             d_l   [DLY];
  logic             d_m   [DLY];
  logic [CNT_W-1:0] d_t   [DLY];

  logic [CNT_W-1:0] cnt [COLS];
  logic [CNT_W-1:0] nx  [COLS];
  logic [CNT_W-1:0] mx;
  logic [COLS-1:0]  hit;

  wire             t_v   = d_v[DLY-1];
  wire             t_l   = d_l[DLY-1];
  wire             t_m   = d_m[DLY-1];
  wire [CNT_W-1:0] t_t   = d_t[DLY-1];
  wire [COLS-1:0]  t_row = d_row[DLY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < DLY; s++) begin
        d_row[s] <= '0;
        d_v[s]   <= 1'b0;
        d_l[s]   <= 1'b0;
        d_m[s]   <= 1'b0;
        d_t[s]   <= '0;
      end
    end else begin
      d_row[0] <= in_row;
      d_v[0]   <= in_valid;
      d_l[0]   <= in_valid & in_last;
      d_m[0]   <= thr_mode;
      d_t[0]   <= thr_level;
      for (int s = 1; s < DLY; s++) begin
        d_row[s] <= d_row[s-1];
        d_v[s]   <= d_v[s-1];
        d_l[s]   <= d_l[s-1];
        d_m[s]   <= d_m[s-1];
        d_t[s]   <= d_t[s-1];
      end
    end
  end

  always_comb begin
    mx = '0;
    for (int c = 0; c < COLS; c++) begin
      nx[c] = (t_v && t_row[c] && cnt[c] != CMAX) ? cnt[c] + 1'b1 : cnt[c];
      if (nx[c] > mx) mx = nx[c];
    end
    for (int c = 0; c < COLS; c++)
      hit[c] = t_m ? (nx[c] == mx && mx != '0) : (nx[c] >= t_t);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) cnt[c] <= '0;
      res_valid <= 1'b0;
      res_bits  <= '0;
    end else begin
      res_valid <= t_l;
      if (t_l) begin
        res_bits <= hit;
        for (int c = 0; c < COLS; c++) cnt[c] <= '0;
      end else begin
        for (int c = 0; c < COLS; c++) cnt[c] <= nx[c];
      end
    end
  end
endmodule

// File: rtl/row_sum_thresh_chk.sv
module row_sum_thresh_chk #(
  parameter int COLS  = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             thr_mode,
  input logic [CNT_W-1:0] thr_level,
  input logic             res_valid,
  input logic [COLS-1:0]  res_bits
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |-> ##5 res_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_last, 5));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_bits));

  a_r3_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(in_valid && in_last && !thr_mode && thr_level == '0, 5))
      |-> (&res_bits));
endmodule

bind row_sum_thresh row_sum_thresh_chk #(.COLS(COLS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .thr_mode(thr_mode), .thr_level(thr_level),
  .res_valid(res_valid), .res_bits(res_bits));

// File: tb/sim_row_sum_thresh.sv
module sim_row_sum_thresh;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, thr_mode = 1'b0;
  logic [31:0] in_row = '0;
  logic [7:0]  thr_level = '0;
  logic        res_valid;
  logic [31:0] res_bits;

  row_sum_thresh u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_row(in_row), .thr_mode(thr_mode), .thr_level(thr_level),
    .res_valid(res_valid), .res_bits(res_bits));

  always #2 clk = ~clk;

  int ntest = 0, nfail = 0, cyc = 0;
  int mcnt [32];
  logic        exp_v [64];
  logic [31:0] exp_b [64];
  logic [31:0] last_b = '0;
  bit          done = 0;

  function automatic logic [31:0] gen(int i);
    logic [31:0] x = i * 32'h9E3779B1;
    return x ^ (x >> 13) ^ (i << 5);
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(logic v, logic l, logic [31:0] row, logic m, logic [7:0] t);
    int mx;
    logic [31:0] bits;
    int s;
    in_valid = v; in_last = l; in_row = row; thr_mode = m; thr_level = t;
    @(negedge clk);
    cyc++;
    if (v) begin
      for (int c = 0; c < 32; c++) if (row[c] && mcnt[c] < 255) mcnt[c]++;
      if (l) begin
        mx = 0;
        for (int c = 0; c < 32; c++) if (mcnt[c] > mx) mx = mcnt[c];
        for (int c = 0; c < 32; c++)
          bits[c] = m ? (mcnt[c] == mx && mx > 0) : (mcnt[c] >= int'(t));
        s = (cyc + 4) % 64;
        exp_v[s] = 1'b1;
        exp_b[s] = bits;
        for (int c = 0; c < 32; c++) mcnt[c] = 0;
      end
    end
    s = cyc % 64;
    if (exp_v[s] || res_valid)
      chk(res_valid === exp_v[s], "R2/R10 res_valid", {31'b0, res_valid}, {31'b0, exp_v[s]});
    if (exp_v[s]) begin
      chk(res_bits === exp_b[s], "R3/R4/R5/R7/R8 res_bits", res_bits, exp_b[s]);
      last_b = exp_b[s];
    end else begin
      chk(res_bits === last_b, "R9 hold", res_bits, last_b);
    end
    exp_v[s] = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, 1'b0, 8'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_b[i] = '0; end
    for (int c = 0; c < 32; c++) mcnt[c] = 0;
    repeat (4) @(negedge clk);
    chk(res_valid === 1'b0, "R1 reset valid", {31'b0, res_valid}, 32'h0);
    chk(res_bits === 32'h0, "R1 reset bits", res_bits, 32'h0);
    rst_n = 1'b1;
    // R1: first pattern starts from zero totals
    step(1'b1, 1'b1, 32'hA5A5_0F0F, 1'b0, 8'd1);
    idle(6);
    // R3: fixed level sweep over multi-row patterns
    for (int t = 0; t < 7; t++) begin
      for (int r = 0; r < 5; r++) step(1'b1, r == 4, gen(t * 8 + r), 1'b0, 8'(t));
      idle(2);
    end
    idle(5);
    // R4: maximum mode, including an all-zero pattern
    for (int p = 0; p < 6; p++) begin
      for (int r = 0; r < 4; r++)
        step(1'b1, r == 3, (p == 0) ? 32'h0 : (gen(p * 5 + r) & gen(p + r + 40)), 1'b1, 8'd0);
      idle(1);
    end
    idle(5);
    // R6: invalid cycles with junk rows and raised in_last
    for (int r = 0; r < 6; r++) begin
      step(1'b1, 1'b0, gen(100 + r), 1'b0, 8'd0);
      step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 8'd0);
    end
    step(1'b1, 1'b1, gen(120), 1'b0, 8'd3);
    idle(6);
    // R7 and R5: back-to-back patterns, mode/level varied on non-final rows
    for (int p = 0; p < 10; p++) begin
      step(1'b1, 1'b0, gen(200 + p), ~p[0], 8'(p * 37));
      step(1'b1, 1'b1, gen(300 + p), p[0], 8'(p % 3));
    end
    for (int p = 0; p < 8; p++) step(1'b1, 1'b1, gen(400 + p), p[1], 8'd1);
    idle(6);
    // R8: saturation in both modes
    for (int r = 0; r < 300; r++)
      step(1'b1, r == 299, (r < 254) ? 32'h3 : 32'h1, 1'b0, 8'd255);
    idle(6);
    for (int r = 0; r < 300; r++)
      step(1'b1, r == 299, (r < 260) ? 32'h3 : 32'h1, 1'b1, 8'd0);
    idle(6);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    done = 1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      ntest++; nfail++;
      $display("FAIL watchdog expired R2 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule